// File: doc/BRIEF.md
# Key Matrix Scanner with Wake-Up Interrupt

This block scans a key matrix of four rows by eight columns. It pulls one row strobe low at a time and holds it for a fixed number of scan-clock cycles. It reads the eight column returns, which idle high through external pull-ups and read low when a key on the active row is pressed. After all four rows have been read, it publishes the full 32-bit pressed map on a read port for the host. It drives an active-low interrupt to tell the host that a key is down.

Three control bits are loaded through a simple write strobe: interrupt enable, sleep and standby. Sleep leaves scanning and interrupts exactly as they are. Standby models a stopped clock. The scan sequence freezes and the strobes are parked low. The interrupt then comes straight from the column inputs through logic that needs no clock edge, so a key press can wake the system. A static pin sets how many keys can wake the system in standby: only row 0, or all four rows. On leaving standby, scanning restarts at row 0.

Top module: `keyscan_wake`

## Requirements
- R1: Outside standby, exactly one strobe is low at a time. Rows are visited in the order 0, 1, 2, 3 and then back to 0, and each row stays low for SLOT_CYCLES clock cycles.
- R2: The key-state output maps key (row r, column c) to bit r*8+c. A bit reads 1 when the key is pressed. The map is refreshed only at the end of a complete four-row scan.
- R3: With interrupt enable set and standby off, irq_n is low while the latched key map has any bit set, and high while it is all zero.
- R4: With interrupt enable clear, irq_n stays high whatever the key inputs do. This holds in normal mode and in standby.
- R5: Once a scan cycle latches a press, irq_n stays low for that whole following scan cycle of 4*SLOT_CYCLES clocks, even if the key is released at once.
- R6: Setting the sleep bit has no effect on the strobe sequence, on key capture or on interrupt generation.
- R7: In standby with wake_all low, kst_n is held at 4'b1110. Only row-0 keys pull irq_n low, and they do so without any clock edge. Keys on other rows leave irq_n high.
- R8: In standby with wake_all high, kst_n is held at 4'b0000, and a key on any row pulls irq_n low without a clock edge. The latched key map does not change while in standby.
- R9: On leaving standby, kst_n reads 4'b1110 at once and holds it for SLOT_CYCLES cycles before row 1 follows.
- R10: Reset clears the key map, drives irq_n high, clears interrupt enable, sleep and standby, and starts the scan at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Loads the three control bits below |
| ctl_ien | input | 1 | Interrupt enable value to load |
| ctl_sleep | input | 1 | Sleep value to load |
| ctl_stby | input | 1 | Standby value to load |
| wake_all | input | 1 | Static pin: 1 lets all rows wake the system in standby, 0 only row 0 |
| kin | input | COLS | Column return inputs, low when pressed on the active row |
| kst_n | output | ROWS | Row strobes, active low |
| key_state | output | ROWS*COLS | Latched pressed map, 1 = pressed |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Capture is tried with four press maps. A single key at bit 0 and a single key at bit 31 catch reversed row or column order. A mixed map with a different pattern on each row catches rows written to the wrong slice. The all-pressed map catches a row that is never sampled. The interrupt is tried with no keys, with one held key, and with a key released right after detection; the last case separates a hold for the whole scan cycle from a level that just follows the inputs. Standby is tried with keys on row 0 and on other rows, in both wake_all settings, with no clock edge between the press and the check, which shows that the wake path really needs no clock.

// File: rtl/kscan_pkg.sv
`timescale 1ns/1ps
package kscan_pkg;
    typedef struct packed {
        logic ien;
        logic sleep;
        logic stby;
    } kscan_ctl_t;
endpackage

// File: rtl/kscan_seq.sv
`timescale 1ns/1ps
module kscan_seq #(
    parameter int ROWS        = 4,
    parameter int SLOT_CYCLES = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stby,
    input  logic            wake_all,
    output logic [ROWS-1:0] strobe_n,
    output logic [RW-1:0]   row,
    output logic            sample,
    output logic            cycle_end
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [SW-1:0] slot;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_slot, last_row;

    always_comb begin
        seq_d     = seq_q;
        last_slot = (seq_q.slot == SW'(SLOT_CYCLES - 1));
        last_row  = (seq_q.row == RW'(ROWS - 1));
        if (stby) begin
            seq_d = '0;
        end else if (last_slot) begin
            seq_d.slot = '0;
            seq_d.row  = last_row ? '0 : seq_q.row + RW'(1);
        end else begin
            seq_d.slot = seq_q.slot + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign row       = seq_q.row;
    assign sample    = !stby && last_slot;
    assign cycle_end = sample && last_row;

    for (genvar r = 0; r < ROWS; r++) begin : g_strobe
        if (r == 0) begin : g_first
            assign strobe_n[r] = stby ? 1'b0 : (seq_q.row != RW'(r));
        end else begin : g_rest
            assign strobe_n[r] = stby ? !wake_all : (seq_q.row != RW'(r));
        end
    end

    // R1
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stby |-> ($countones(strobe_n) == ROWS - 1));

    // R1
    row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stby && !last_slot) |=> ($stable(seq_q.row) || $past(stby)));
endmodule

// File: rtl/kscan_capture.sv
`timescale 1ns/1ps
module kscan_capture #(
    parameter int ROWS = 4,
    parameter int COLS = 8,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int KEYS = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] kin,
    input  logic [RW-1:0]   row,
    input  logic            sample,
    input  logic            cycle_end,
    output logic [KEYS-1:0] key_state
);
    typedef struct packed {
        logic [KEYS-1:0] shadow;
        logic [KEYS-1:0] state;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [KEYS-1:0] merged;

    always_comb begin
        cap_d  = cap_q;
        merged = cap_q.shadow;
        merged[int'(row) * COLS +: COLS] = ~kin;
        if (sample)    cap_d.shadow = merged;
        if (cycle_end) cap_d.state  = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign key_state = cap_q.state;

    // R2
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_end |=> $stable(key_state));
endmodule

// File: rtl/kscan_irq.sv
`timescale 1ns/1ps
module kscan_irq #(
    parameter int COLS = 8,
    parameter int KEYS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_ien,
    input  logic            ctl_sleep,
    input  logic            ctl_stby,
    input  logic [COLS-1:0] kin,
    input  logic [KEYS-1:0] key_state,
    output logic            stby,
    output logic            irq_n
);
    import kscan_pkg::*;

    kscan_ctl_t ctl_d, ctl_q;
    logic       wake_hit;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_wr) begin
            ctl_d.ien   = ctl_ien;
            ctl_d.sleep = ctl_sleep;
            ctl_d.stby  = ctl_stby;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign wake_hit = ctl_q.stby ? !(&kin) : (|key_state);
    assign irq_n    = !(ctl_q.ien && wake_hit);
    assign stby     = ctl_q.stby;

    // R4
    ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.ien |-> irq_n);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.stby && !$past(ctl_q.stby) && $stable(ctl_q.ien) && $stable(key_state))
        |-> $stable(irq_n));

    // R6
    sleep_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sleep && !ctl_q.stby && ctl_q.ien && (|key_state)) |-> !irq_n);
endmodule

// File: rtl/keyscan_wake.sv
`timescale 1ns/1ps
module keyscan_wake #(
    parameter int ROWS        = 4,
    parameter int COLS        = 8,
    parameter int SLOT_CYCLES = 4,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int KEYS = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic            ctl_ien,
    input  logic            ctl_sleep,
    input  logic            ctl_stby,
    input  logic            wake_all,
    input  logic [COLS-1:0] kin,
    output logic [ROWS-1:0] kst_n,
    output logic [KEYS-1:0] key_state,
    output logic            irq_n
);
    logic          stby;
    logic [RW-1:0] row;
    logic          sample;
    logic          cycle_end;

    kscan_seq #(.ROWS(ROWS), .SLOT_CYCLES(SLOT_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .stby(stby), .wake_all(wake_all),
        .strobe_n(kst_n), .row(row), .sample(sample), .cycle_end(cycle_end)
    );

    kscan_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
        .clk(clk), .rst_n(rst_n), .kin(kin), .row(row), .sample(sample),
        .cycle_end(cycle_end), .key_state(key_state)
    );

    kscan_irq #(.COLS(COLS), .KEYS(KEYS)) u_irq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_ien(ctl_ien),
        .ctl_sleep(ctl_sleep), .ctl_stby(ctl_stby), .kin(kin),
        .key_state(key_state), .stby(stby), .irq_n(irq_n)
    );

    // R7
    park_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stby && !wake_all) |-> (kst_n == {{(ROWS-1){1'b1}}, 1'b0}));

    // R8
    park_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stby && wake_all) |-> (kst_n == '0));

    // R8
    frozen_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stby && $past(stby)) |-> $stable(key_state));

    // R9
    resume_row0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stby) |-> (kst_n == {{(ROWS-1){1'b1}}, 1'b0}));
endmodule

// File: tb/keyscan_wake_tb.sv
`timescale 1ns/1ps
module keyscan_wake_tb;
    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int SLOT = 4;
    localparam int SCAN = ROWS * SLOT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_ien = 1'b0, ctl_sleep = 1'b0, ctl_stby = 1'b0;
    logic wake_all = 1'b0;
    logic [COLS-1:0] kin;
    logic [ROWS-1:0] kst_n;
    logic [ROWS*COLS-1:0] key_state;
    logic irq_n;
    logic [ROWS*COLS-1:0] pressed = '0;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    keyscan_wake #(.ROWS(ROWS), .COLS(COLS), .SLOT_CYCLES(SLOT)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_ien(ctl_ien),
        .ctl_sleep(ctl_sleep), .ctl_stby(ctl_stby), .wake_all(wake_all),
        .kin(kin), .kst_n(kst_n), .key_state(key_state), .irq_n(irq_n)
    );

    // matrix model: a column reads low if a pressed key sits on a low strobe
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            kin[c] = 1'b1;
            for (int r = 0; r < ROWS; r++)
                if (pressed[r*COLS+c] && !kst_n[r]) kin[c] = 1'b0;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input bit ien, input bit slp, input bit sb);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_ien = ien; ctl_sleep = slp; ctl_stby = sb;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sync_row0();
        logic [ROWS-1:0] prev;
        @(negedge clk);
        prev = kst_n;
        for (int i = 0; i < 4*SCAN; i++) begin
            @(negedge clk);
            if (kst_n == 4'b1110 && prev != 4'b1110) break;
            prev = kst_n;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(key_state == '0, "R10 key map", key_state, 0);
        check(irq_n == 1'b1, "R10 irq", irq_n, 1);
        check(kst_n == 4'b1110, "R10 row0", kst_n, 4'b1110);
    endtask

    task automatic t_strobes(input string tag);
        sync_row0();
        for (int r = 0; r < ROWS; r++)
            for (int s = 0; s < SLOT; s++) begin
                check(kst_n == ~(4'b1 << r), tag, kst_n, ~(4'b1 << r));
                @(negedge clk);
            end
        check(kst_n == 4'b1110, tag, kst_n, 4'b1110);
    endtask

    task automatic t_capture(input logic [31:0] pat);
        pressed = pat;
        wait_cyc(2*SCAN + 2);
        check(key_state == pat, "R2 capture", key_state, pat);
        pressed = '0;
        wait_cyc(2*SCAN + 2);
        check(key_state == '0, "R2 release", key_state, 0);
    endtask

    task automatic t_irq();
        wr_ctl(1, 0, 0);
        wait_cyc(2*SCAN);
        check(irq_n == 1'b1, "R3 idle", irq_n, 1);
        pressed = 32'h0000_4000;
        wait_cyc(2*SCAN + 2);
        check(irq_n == 1'b0, "R3 pressed", irq_n, 0);
        pressed = '0;
        wait_cyc(2*SCAN + 2);
        check(irq_n == 1'b1, "R3 released", irq_n, 1);
    endtask

    task automatic t_hold();
        int lows = 0;
        pressed = 32'h0000_0004;
        for (int i = 0; i < 4*SCAN; i++) begin
            @(negedge clk);
            if (!irq_n) break;
        end
        check(irq_n == 1'b0, "R5 detect", irq_n, 0);
        pressed = '0;
        lows = 1;
        for (int i = 0; i < 4*SCAN; i++) begin
            @(negedge clk);
            if (irq_n) break;
            lows++;
        end
        check(lows == SCAN, "R5 hold length", lows, SCAN);
    endtask

    task automatic t_ien_off();
        wr_ctl(0, 0, 0);
        pressed = 32'h8000_0001;
        wait_cyc(2*SCAN + 2);
        check(key_state == 32'h8000_0001, "R4 capture still runs", key_state, 32'h8000_0001);
        check(irq_n == 1'b1, "R4 normal masked", irq_n, 1);
        pressed = '0;
        wait_cyc(2*SCAN + 2);
        wake_all = 1'b1;
        wr_ctl(0, 0, 1);
        pressed = 32'h0100_0000;
        #1;
        check(irq_n == 1'b1, "R4 standby masked", irq_n, 1);
        pressed = '0;
        wr_ctl(0, 0, 0);
        wake_all = 1'b0;
    endtask

    task automatic t_sleep();
        wr_ctl(1, 1, 0);
        t_strobes("R6 strobes in sleep");
        pressed = 32'h0020_0000;
        wait_cyc(2*SCAN + 2);
        check(key_state == 32'h0020_0000, "R6 capture in sleep", key_state, 32'h0020_0000);
        check(irq_n == 1'b0, "R6 irq in sleep", irq_n, 0);
        pressed = '0;
        wait_cyc(2*SCAN + 2);
        wr_ctl(1, 0, 0);
    endtask

    task automatic t_stby_narrow();
        wake_all = 1'b0;
        wr_ctl(1, 0, 1);
        check(kst_n == 4'b1110, "R7 parked", kst_n, 4'b1110);
        wait_cyc(20);
        check(kst_n == 4'b1110, "R7 still parked", kst_n, 4'b1110);
        check(irq_n == 1'b1, "R7 idle", irq_n, 1);
        #2;
        pressed = 32'h0000_0200;
        #1;
        check(irq_n == 1'b1, "R7 row1 ignored", irq_n, 1);
        pressed = 32'h0000_0008;
        #1;
        check(irq_n == 1'b0, "R7 row0 wakes", irq_n, 0);
        wait_cyc(2*SCAN);
        check(key_state == '0, "R7 map frozen", key_state, 0);
        pressed = '0;
        #1;
        check(irq_n == 1'b1, "R7 release", irq_n, 1);
    endtask

    task automatic t_stby_wide();
        wake_all = 1'b1;
        @(negedge clk);
        check(kst_n == 4'b0000, "R8 parked all", kst_n, 0);
        #2;
        pressed = 32'h4000_0000;
        #1;
        check(irq_n == 1'b0, "R8 row3 wakes", irq_n, 0);
        wait_cyc(2*SCAN);
        check(key_state == '0, "R8 map frozen", key_state, 0);
        pressed = '0;
        #1;
        check(irq_n == 1'b1, "R8 release", irq_n, 1);
    endtask

    task automatic t_exit();
        int held = 0;
        wr_ctl(1, 0, 0);
        wake_all = 1'b0;
        check(kst_n == 4'b1110, "R9 resume row0", kst_n, 4'b1110);
        while (kst_n == 4'b1110 && held < 4*SLOT) begin
            held++;
            @(negedge clk);
        end
        check(held == SLOT, "R9 row0 length", held, SLOT);
        check(kst_n == 4'b1101, "R9 next row1", kst_n, 4'b1101);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_strobes("R1 strobe order");
        t_capture(32'h0000_0001);
        t_capture(32'h8000_0000);
        t_capture(32'hA50F_813C);
        t_capture(32'hFFFF_FFFF);
        t_irq();
        t_hold();
        t_ien_off();
        t_sleep();
        t_stby_narrow();
        t_stby_wide();
        t_exit();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule